// File: doc/BRIEF.md
# Comma Word Boundary Aligner

This block sits between clock recovery and the 8b10b decoder of a serial receiver. It takes one recovered bit on every clock and shifts it into a ten-bit window. The window is checked on every bit for the seven-bit comma prefix, in either polarity. The first comma after reset fixes the word boundary. From then on, a modulo-ten slot counter hands a ten-bit code group to the decoder on every tenth bit.

A comma that appears off the current boundary re-phases the counter, so the word that carries it is delivered at once. Later words follow every ten bits from that point. A comma on the expected boundary leaves the counter alone. A lock flag rises once a comma is seen on a boundary that an earlier comma already set. A comma that moves the boundary clears the lock. Each delivered word has its first-received bit in bit 0.

Top module: `comma_word_aligner`

## Requirements
- R1: While rst_n is low at a clock edge, the edge clears word_vld, comma_pulse and locked, and fills the bit window with zeros.
- R2: A delivered word_out holds the ten most recent bits, with the earliest of them in bit 0 and the latest in bit 9.
- R3: A comma is a window whose seven earliest bits arrived as 0,0,1,1,1,1,1 or as 1,1,0,0,0,0,0. Call the edge that captures the tenth bit of that window edge k. At edge k+1, word_vld and comma_pulse are both high for one cycle.
- R4: A comma that is off the current boundary is delivered at the edge after its tenth bit. The following words come every ten bits from it.
- R5: Once a comma has been seen, word_vld pulses exactly once every ten bits when no comma intervenes.
- R6: A comma that falls on the expected boundary does not change the spacing of later words.
- R7: locked rises at the edge that delivers a comma lying on a boundary set by an earlier comma.
- R8: A comma off the expected boundary clears locked at the edge that delivers it.
- R9: No word_vld is raised before the first comma after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one recovered bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Recovered serial bit |
| word_out | output | 10 | Aligned code group, first-received bit in bit 0 |
| word_vld | output | 1 | One-cycle strobe: word_out holds a code group |
| comma_pulse | output | 1 | One-cycle pulse: the delivered group is a comma |
| locked | output | 1 | Two commas have agreed on the same boundary |

## Verification
On every cycle, the assertions check these relations:
- The counter steps by one between boundaries and returns to zero after any comma.
- locked only rises on a comma that arrives with a confirmed boundary, and only falls on a comma that arrives off the boundary.
- A comma pulse always comes with a word strobe.
- No word is strobed before a comma has been seen.

Only the bench's bit streams can show the rest:
- The exact cycle at which each word appears.
- That the bit order inside word_out is correct.
- That spacing holds after a slipped stream.
- That both comma polarities are found.

To cover these, the bench predicts every strobe position from the bit history alone.

// File: rtl/cwa_pkg.sv
// Shared constants for the comma word aligner.
// Assumes ten-bit code groups and a seven-bit comma prefix that arrives
// first-bit-first. Bit 0 of the pattern is the earliest bit.
package cwa_pkg;
    localparam int WORD_W  = 10;
    localparam int COMMA_W = 7;
    // arrival order 0,0,1,1,1,1,1 read with the earliest bit in bit 0
    localparam logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100;
endpackage

// File: rtl/cwa_window.sv
// Serial-in window with comma detection.
// Each new bit enters at the top and moves toward bit 0, so after WORD_W
// bits the earliest bit of the group sits in bit 0. The comma compare looks
// at the COMMA_W earliest bits and accepts either polarity.
// Assumes exactly one valid bit per clock.
module cwa_window #(
    parameter int WORD_W  = 10,
    parameter int COMMA_W = 7,
    parameter logic [COMMA_W-1:0] COMMA_PAT = 7'b1111100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [WORD_W-1:0] win,
    output logic              comma_hit
);
    logic [COMMA_W-1:0] head;

    // shift each arriving bit in from the top
    always_ff @(posedge clk) begin
        if (!rst_n) win <= '0;
        else        win <= {bit_in, win[WORD_W-1:1]};
    end

    // compare the earliest bits against the comma prefix in both polarities
    always_comb begin
        head      = win[COMMA_W-1:0];
        comma_hit = (head == COMMA_PAT) || (head == ~COMMA_PAT);
    end
endmodule

// File: rtl/cwa_slot_ctr.sv
// Modulo-WORD_W slot counter.
// It marks the cycle in which the window holds a complete word. Any comma
// hit forces that cycle to be a boundary and re-phases the count, so a hit
// that lands on the expected slot leaves the sequence unchanged.
module cwa_slot_ctr #(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic comma_hit,
    output logic slot_end,
    output logic boundary
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt;

    // decode the boundary for the current window
    always_comb begin
        slot_end = (cnt == LAST);
        boundary = slot_end || comma_hit;
    end

    // advance the slot count, restarting after every boundary
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (boundary) cnt <= '0;
        else               cnt <= cnt + CNT_W'(1);
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> cnt == $past(cnt) + CNT_W'(1));
    p_rephase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        comma_hit |=> cnt == '0);
endmodule

// File: rtl/cwa_lock.sv
// Boundary lock tracker.
// It records that a comma has set the boundary. It raises the lock when a
// later comma falls on that boundary, and drops it when a comma moves the
// boundary. Assumes slot_end and comma_hit describe the same window.
module cwa_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic comma_hit,
    input  logic slot_end,
    output logic seen,
    output logic locked
);
    // remember that some comma has defined a boundary
    always_ff @(posedge clk) begin
        if (!rst_n)         seen <= 1'b0;
        else if (comma_hit) seen <= 1'b1;
    end

    // confirm or drop the lock on each comma
    always_ff @(posedge clk) begin
        if (!rst_n)                          locked <= 1'b0;
        else if (comma_hit && !slot_end)     locked <= 1'b0;
        else if (comma_hit && seen)          locked <= 1'b1;
    end

    p_lock_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(comma_hit) && $past(slot_end) && $past(seen));
    p_lock_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(comma_hit) && !$past(slot_end));
    p_lock_after_seen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> seen);
endmodule

// File: rtl/comma_word_aligner.sv
// Comma-based word boundary aligner.
// Recovered bits are shifted in one per clock. A comma prefix sets the
// ten-bit boundary, and code groups go to the decoder with a strobe, a
// comma pulse and a lock flag. All outputs appear one clock after the
// window that holds the group.
module comma_word_aligner #(
    parameter int WORD_W  = cwa_pkg::WORD_W,
    parameter int COMMA_W = cwa_pkg::COMMA_W,
    parameter logic [COMMA_W-1:0] COMMA_PAT = cwa_pkg::COMMA_PAT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word_out,
    output logic              word_vld,
    output logic              comma_pulse,
    output logic              locked
);
    logic [WORD_W-1:0] win;
    logic              comma_hit;
    logic              slot_end;
    logic              boundary;
    logic              seen;

    cwa_window #(.WORD_W(WORD_W), .COMMA_W(COMMA_W), .COMMA_PAT(COMMA_PAT)) u_win (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .win(win), .comma_hit(comma_hit)
    );

    cwa_slot_ctr #(.WORD_W(WORD_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .comma_hit(comma_hit),
        .slot_end(slot_end), .boundary(boundary)
    );

    cwa_lock u_lock (
        .clk(clk), .rst_n(rst_n), .comma_hit(comma_hit), .slot_end(slot_end),
        .seen(seen), .locked(locked)
    );

    // register the delivered group and its strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out    <= '0;
            word_vld    <= 1'b0;
            comma_pulse <= 1'b0;
        end else begin
            word_vld    <= boundary && (seen || comma_hit);
            comma_pulse <= comma_hit;
            if (boundary) word_out <= win;
        end
    end

    p_pulse_has_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        comma_pulse |-> word_vld);
    p_no_word_before_comma_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> seen);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !word_vld && !comma_pulse && !locked);
endmodule

// File: tb/tb_comma_word_aligner.sv
// Bench for the comma word aligner.
// It feeds bit streams and predicts every output from the bit history alone.
module tb_comma_word_aligner;
    localparam int W = 10;
    localparam int OFS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bit_in = 1'b0;
    logic [W-1:0] word_out;
    logic         word_vld, comma_pulse, locked;

    int checks = 0;
    int errors = 0;

    // arrival history; the first OFS slots stand for the zeroed window
    logic hist [0:8191];
    int   nbits = 0;
    bit   m_seen = 0;
    bit   m_lock = 0;
    int   last_e = 0;
    string tag = "R9";

    // expectation for the previous bit
    bit           p_have = 0;
    bit           p_vld, p_com, p_lock;
    logic [W-1:0] p_word;

    always #2 clk = ~clk;

    comma_word_aligner dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .word_out(word_out),
        .word_vld(word_vld), .comma_pulse(comma_pulse), .locked(locked)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at bit %0d", req, act, exp, nbits);
        end
    endtask

    function automatic bit is_comma(input int k);
        int b = k + OFS;
        bit pos = (hist[b-9] == 0) && (hist[b-8] == 0) && hist[b-7] && hist[b-6]
                  && hist[b-5] && hist[b-4] && hist[b-3];
        bit neg = hist[b-9] && hist[b-8] && (hist[b-7] == 0) && (hist[b-6] == 0)
                  && (hist[b-5] == 0) && (hist[b-4] == 0) && (hist[b-3] == 0);
        return pos || neg;
    endfunction

    task automatic send_bit(input logic b);
        int  k;
        bit  cm, due, emit;
        logic [W-1:0] wd;
        bit_in = b;
        @(posedge clk);
        k = nbits;
        hist[k + OFS] = b;
        nbits++;
        cm  = is_comma(k);
        due = m_seen && (k == last_e + W);
        emit = cm || due;
        if (cm) begin
            if (due) m_lock = 1;
            else     m_lock = 0;
            m_seen = 1;
            last_e = k;
        end else if (due) begin
            last_e = k;
        end
        for (int i = 0; i < W; i++) wd[i] = hist[k + OFS - 9 + i];
        @(negedge clk);
        if (p_have) begin
            check(word_vld == p_vld, tag, word_vld, p_vld);
            if (p_vld) begin
                check(word_out == p_word, "R2", word_out, p_word);
                check(comma_pulse == p_com, "R3", comma_pulse, p_com);
            end
            check(locked == p_lock, tag, locked, p_lock);
        end
        p_have = 1; p_vld = emit; p_com = cm; p_lock = m_lock; p_word = wd;
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) send_bit(w[i]);
    endtask

    // K28.5 arriving 0011111010 and 1100000101, earliest bit in bit 0
    localparam logic [W-1:0] KPOS = 10'b0101111100;
    localparam logic [W-1:0] KNEG = 10'b1010000011;
    localparam logic [W-1:0] ALT  = 10'b1010101010;

    initial begin
        repeat (OFS) hist[0] = 0;
        for (int i = 0; i < OFS; i++) hist[i] = 0;
        @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            check(!word_vld && !comma_pulse && !locked, "R1",
                  {word_vld, comma_pulse, locked}, 0);
        end
        rst_n = 1'b1;

        tag = "R9";
        for (int i = 0; i < 35; i++) send_bit(i[0]);
        check(!word_vld, "R9", word_vld, 0);

        tag = "R3";
        send_word(KPOS);
        send_word(ALT); send_word(ALT);
        tag = "R7";
        send_word(KNEG);
        send_word(ALT);
        check(locked == 1'b1, "R7", locked, 1);

        tag = "R6";
        send_word(ALT); send_word(KPOS); send_word(ALT); send_word(ALT);
        check(locked == 1'b1, "R6", locked, 1);

        tag = "R8";
        send_bit(0); send_bit(1); send_bit(0);
        send_word(KPOS);
        send_bit(0);
        check(locked == 1'b0, "R8", locked, 0);
        tag = "R4";
        for (int i = 0; i < W-1; i++) send_bit(ALT[i]);
        send_word(ALT); send_word(KNEG); send_word(ALT);
        check(locked == 1'b1, "R4", locked, 1);

        tag = "R5";
        void'($urandom(32'h5EED1));
        for (int r = 0; r < 30; r++) begin
            int gap = $urandom % 26;
            for (int i = 0; i < gap; i++) send_bit(1'($urandom % 2));
            send_word((r % 2 == 0) ? KPOS : KNEG);
            send_word(W'($urandom));
            send_word(ALT);
        end
        send_word(ALT);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule